// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block sits between an external Ethernet block and the Ethernet channel of a fronthaul link. It takes 4-bit nibbles from an MII-style transmit interface and turns them into a framed symbol stream. Each output symbol is a type tag plus a 4-bit value. A downstream line encoder maps that pair to line codes. Both the line encoding and the link multiplexing are outside this block.

The framer controls the flow with a ready output. After ready rises, the external block raises its enable. The first cycle with enable high starts a packet: the framer sends a J symbol and then a K symbol, and it ignores the nibbles offered during those cycles. After the K symbol, every nibble taken while enable is high becomes a DATA symbol. A HALT symbol replaces any nibble that arrives with the error input high. When enable falls, the framer closes the packet with T and R and then goes back to idle. A stall input from the link side freezes the block, so no symbol is lost while the link is not accepting.

All outputs come from registers. Reset is synchronous and active high.

Top module: `mii_tx_framer`

## Requirements
- R1: During and after reset, `tx_rdy` is 0, `sym_type` is IDLE and `sym_val` is 0. The type codes are IDLE=0, J=1, K=2, DATA=3, T=4, R=5 and HALT=6, and every symbol other than DATA carries value 0.
- R2: One cycle after an IDLE symbol is sent from the rest state, `tx_rdy` rises. While `tx_en` stays low the framer keeps `tx_rdy` high and sends IDLE every cycle.
- R3: The first edge that sees `tx_en` high while waiting sends J, with `tx_rdy` low. The next edge sends K and raises `tx_rdy`. The nibbles and the error input offered in those two cycles are ignored.
- R4: After K, each edge that sees `tx_en` high with `tx_rdy` high sends DATA, with `sym_val` equal to the `tx_d` nibble present before that edge.
- R5: A nibble taken with `tx_er` high is sent as HALT with value 0 instead of DATA.
- R6: An edge that sees `tx_en` low after K or during data sends T. Then come R and then IDLE, with `tx_rdy` low across all three. A packet with no data gives J, K, T, R.
- R7: `tx_en` and `tx_d` have no effect while `tx_rdy` is low in the rest state. The framer still only raises `tx_rdy` and sends IDLE.
- R8: While `link_stall` is high, the state, `tx_rdy`, `sym_type` and `sym_val` all hold their values. The sequence then resumes with no symbol skipped.
- R9: Reset overrides `link_stall` and any packet in progress, and returns the block to the R1 state at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| link_stall | input | 1 | Link side not accepting; freezes the block |
| tx_rdy | output | 1 | Framer can take a nibble |
| tx_en | input | 1 | External block is presenting a packet nibble |
| tx_er | input | 1 | Current nibble is a coding error |
| tx_d | input | 4 | Transmit nibble |
| sym_type | output | 3 | Output symbol type code |
| sym_val | output | 4 | Output symbol value |

## Verification
The assertions assume that the external side only ever sees the framer's own registered `tx_rdy`. They also assume that `link_stall` and the MII inputs change only between edges and never during reset release. The assertions do not depend on what enable does while ready is low, so the stimulus is free to drive enable high in the rest state and with an error during J. This checks that such inputs leave the sequence unchanged. All stimulus changes on the falling clock edge, so every input is stable at the rising edge that samples it.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  typedef enum logic [2:0] {
    SYM_IDLE = 3'd0,
    SYM_J    = 3'd1,
    SYM_K    = 3'd2,
    SYM_DATA = 3'd3,
    SYM_T    = 3'd4,
    SYM_R    = 3'd5,
    SYM_HALT = 3'd6
  } sym_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SOPJ,
    ST_SOPK,
    ST_DATA,
    ST_EOPT,
    ST_EOPR
  } fsm_st_e;
endpackage

// File: rtl/mtf_ctrl.sv
module mtf_ctrl
  import mtf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stall,
  input  logic      en,
  output sym_kind_e kind_d,
  output logic      take,
  output logic      rdy_q
);
  fsm_st_e st_q, st_d;
  logic    rdy_d;

  always_comb begin
    st_d   = st_q;
    kind_d = SYM_IDLE;
    unique case (st_q)
      ST_IDLE: begin
        st_d   = ST_WAIT;
        kind_d = SYM_IDLE;
      end
      ST_WAIT: begin
        if (en) begin
          st_d   = ST_SOPJ;
          kind_d = SYM_J;
        end
      end
      ST_SOPJ: begin
        st_d   = ST_SOPK;
        kind_d = SYM_K;
      end
      ST_SOPK, ST_DATA: begin
        if (en) begin
          st_d   = ST_DATA;
          kind_d = SYM_DATA;
        end else begin
          st_d   = ST_EOPT;
          kind_d = SYM_T;
        end
      end
      ST_EOPT: begin
        st_d   = ST_EOPR;
        kind_d = SYM_R;
      end
      ST_EOPR: begin
        st_d   = ST_IDLE;
        kind_d = SYM_IDLE;
      end
      default: begin
        st_d   = ST_IDLE;
        kind_d = SYM_IDLE;
      end
    endcase
  end

  assign rdy_d = (st_d == ST_WAIT) || (st_d == ST_SOPK) || (st_d == ST_DATA);
  assign take  = en && ((st_q == ST_SOPK) || (st_q == ST_DATA));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rdy_q <= 1'b0;
    end else if (!stall) begin
      st_q  <= st_d;
      rdy_q <= rdy_d;
    end
  end

  // R8: a stall freezes sequencing state and ready
  p_stall_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(st_q) && $stable(rdy_q)));

  // R3: ready is low while J is on the output
  p_sopj_no_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SOPJ) |-> !rdy_q);

  // R6: ready is low during the end delimiter
  p_eop_no_rdy_r6: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_EOPT) || (st_q == ST_EOPR)) |-> !rdy_q);

  // R4: a nibble is only taken while ready is shown
  p_take_needs_rdy_r4: assert property (@(posedge clk) disable iff (rst)
    take |-> rdy_q);
endmodule

// File: rtl/mtf_sym.sv
module mtf_sym
  import mtf_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  sym_kind_e     kind_d,
  input  logic          take,
  input  logic          er,
  input  logic [DW-1:0] d,
  output sym_kind_e     kind_q,
  output logic [DW-1:0] val_q
);
  localparam logic [DW-1:0] ZV = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= SYM_IDLE;
      val_q  <= ZV;
    end else if (!stall) begin
      if (take && er) begin
        kind_q <= SYM_HALT;
        val_q  <= ZV;
      end else if (take) begin
        kind_q <= SYM_DATA;
        val_q  <= d;
      end else begin
        kind_q <= kind_d;
        val_q  <= ZV;
      end
    end
  end

  // R5: an errored nibble leaves as HALT with zero value
  p_halt_on_err_r5: assert property (@(posedge clk) disable iff (rst)
    (!stall && take && er) |=> (kind_q == SYM_HALT && val_q == ZV));

  // R3: J is always followed by K
  p_j_then_k_r3: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind_q == SYM_J) |=> (kind_q == SYM_K));

  // R6: T is always followed by R
  p_t_then_r_r6: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind_q == SYM_T) |=> (kind_q == SYM_R));

  // R8: output symbol holds during stall
  p_sym_hold_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(kind_q) && $stable(val_q)));
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mtf_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_stall,
  output logic          tx_rdy,
  input  logic          tx_en,
  input  logic          tx_er,
  input  logic [DW-1:0] tx_d,
  output logic [2:0]    sym_type,
  output logic [DW-1:0] sym_val
);
  sym_kind_e kind_d, kind_q;
  logic      take;

  mtf_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stall  (link_stall),
    .en     (tx_en),
    .kind_d (kind_d),
    .take   (take),
    .rdy_q  (tx_rdy)
  );

  mtf_sym #(.DW(DW)) u_sym (
    .clk    (clk),
    .rst    (rst),
    .stall  (link_stall),
    .kind_d (kind_d),
    .take   (take),
    .er     (tx_er),
    .d      (tx_d),
    .kind_q (kind_q),
    .val_q  (sym_val)
  );

  assign sym_type = kind_q;
endmodule

// File: tb/test_mii_tx_framer.sv
`timescale 1ns/1ps
module test_mii_tx_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       link_stall = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] tx_d = 4'h0;
  logic       tx_rdy;
  logic [2:0] sym_type;
  logic [3:0] sym_val;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mii_tx_framer i_mii_tx_framer (
    .clk        (clk),
    .rst        (rst),
    .link_stall (link_stall),
    .tx_rdy     (tx_rdy),
    .tx_en      (tx_en),
    .tx_er      (tx_er),
    .tx_d       (tx_d),
    .sym_type   (sym_type),
    .sym_val    (sym_val)
  );

  // vector: {stall, en, er, d[3:0], exp_rdy, exp_type[2:0], exp_val[3:0]}
  localparam int NV = 18;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,4'h0, 1'b1,3'd0,4'h0}, // R2
    {1'b0,1'b0,1'b0,4'h0, 1'b1,3'd0,4'h0}, // R2
    {1'b0,1'b1,1'b0,4'h5, 1'b0,3'd1,4'h0}, // R3 J
    {1'b0,1'b1,1'b0,4'h7, 1'b1,3'd2,4'h0}, // R3 K
    {1'b0,1'b1,1'b0,4'hA, 1'b1,3'd3,4'hA}, // R4
    {1'b0,1'b1,1'b1,4'h3, 1'b1,3'd6,4'h0}, // R5 HALT
    {1'b1,1'b1,1'b0,4'hC, 1'b1,3'd6,4'h0}, // R8 hold
    {1'b0,1'b1,1'b0,4'hC, 1'b1,3'd3,4'hC}, // R4
    {1'b0,1'b0,1'b0,4'h0, 1'b0,3'd4,4'h0}, // R6 T
    {1'b1,1'b0,1'b0,4'h0, 1'b0,3'd4,4'h0}, // R8 hold
    {1'b0,1'b0,1'b0,4'h0, 1'b0,3'd5,4'h0}, // R6 R
    {1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,4'h0}, // R6 idle
    {1'b0,1'b1,1'b0,4'hF, 1'b1,3'd0,4'h0}, // R7 ignored
    {1'b0,1'b1,1'b0,4'h9, 1'b0,3'd1,4'h0}, // R3 J
    {1'b0,1'b1,1'b1,4'h6, 1'b1,3'd2,4'h0}, // R3 er ignored
    {1'b0,1'b0,1'b0,4'h0, 1'b0,3'd4,4'h0}, // R6 empty
    {1'b0,1'b0,1'b0,4'h0, 1'b0,3'd5,4'h0}, // R6
    {1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,4'h0}  // R6
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:             return "R2";
      2, 3, 13, 14:     return "R3";
      4, 7:             return "R4";
      5:                return "R5";
      6, 9:             return "R8";
      12:               return "R7";
      default:          return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input int er, input int et, input int ev);
    chk(tag, "tx_rdy", int'(tx_rdy), er);
    chk(tag, "sym_type", int'(sym_type), et);
    chk(tag, "sym_val", int'(sym_val), ev);
  endtask

  task automatic step(input logic s, input logic e, input logic r, input logic [3:0] d);
    link_stall = s; tx_en = e; tx_er = r; tx_d = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk_out("R1", 0, 0, 0);
    rst = 1'b0;
    chk_out("R1", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      step(v[14], v[13], v[12], v[11:8]);
      chk_out(vtag(i), int'(v[7]), int'(v[6:4]), int'(v[3:0]));
    end

    // R9: reset in mid-packet while stalled
    step(1'b0, 1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b1, 1'b0, 4'h1);
    step(1'b0, 1'b1, 1'b0, 4'h2);
    step(1'b0, 1'b1, 1'b0, 4'h4);
    chk_out("R4", 1, 3, 4);
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b0, 4'h8);
    chk_out("R9", 0, 0, 0);
    rst = 1'b0;

    // R8: stall while J is shown, then K follows
    step(1'b0, 1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b1, 1'b0, 4'h0);
    chk_out("R3", 0, 1, 0);
    step(1'b1, 1'b1, 1'b0, 4'h0);
    chk_out("R8", 0, 1, 0);
    step(1'b1, 1'b1, 1'b0, 4'h0);
    chk_out("R8", 0, 1, 0);
    step(1'b0, 1'b1, 1'b0, 4'h0);
    chk_out("R8", 1, 2, 0);
    step(1'b0, 1'b1, 1'b1, 4'hB);
    chk_out("R5", 1, 6, 0);
    step(1'b0, 1'b1, 1'b0, 4'hE);
    chk_out("R4", 1, 3, 14);
    step(1'b0, 1'b0, 1'b0, 4'h0);
    chk_out("R6", 0, 4, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule